// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block keeps the fault-confinement bookkeeping of one CAN node. It holds an 8-bit transmit error counter, a 7-bit receive error counter and a receive-passive flag. From these it derives the node state: error-active, error-passive or bus-off. The protocol engine drives it with single-cycle event strobes: errors seen as receiver, error-flag and overload-flag starts, bit errors during a flag, the first bit after a flag being dominant, each further consecutive dominant bit, and frames that completed cleanly. A role input tells the block whether the node is the transmitter of the current frame.

Every counter change lands on the clock edge that samples its event strobe. The engine picks the type of error flag to send from an output that reflects the counters as they stood before that cycle's event. The block counts the runs of dominant bits that follow a flag and adds the penalty for each run. Bus-off is left only after the engine has reported a fixed number of 11-recessive-bit sequences.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters are 0, the receive-passive flag is clear, the state is error-active (code 0), and the warning and passive-flag outputs are low.
- R2: While the node is receiver (`role_tx_i`=0) and the receive-passive flag is clear, `err_det_i` adds 1 to the receive counter. If `err_in_flag_i` is high in the same cycle, the error is ignored.
- R3: While the node is receiver and the receive-passive flag is clear, `first_dom_i` adds 8 to the receive counter.
- R4: While the node is transmitter, `flag_start_i` adds 8 to the transmit counter. It has no effect when `exc_ack_i` or `exc_stuff_i` is high in the same cycle.
- R5: `flag_bit_err_i` adds 8 to the transmit counter while the node is transmitter, and 8 to the receive counter while it is receiver and the receive-passive flag is clear.
- R6: After an active error flag (a `flag_start_i` while `flag_passive_o` is 0) or an overload flag (`ovl_start_i`), the 14th consecutive `dom_bit_i` adds a penalty of 8 to the counter of the current role. Every 8th further bit adds 8 again. After a passive error flag, every 8th bit adds 8. `dom_break_i` or a new flag start restarts the count.
- R7: `tx_ok_i` subtracts 1 from the transmit counter, and a counter at 0 stays at 0.
- R8: `rx_ok_i` subtracts 1 from the receive counter, and a counter at 0 stays at 0. If the receive-passive flag is set, `rx_ok_i` instead loads 119 and clears the flag.
- R9: A receive increment that would take the counter past 127 sets it to 127 and sets the receive-passive flag. While the flag is set, receive increments have no effect.
- R10: An add of 8 to a transmit counter of 248 or more puts the node in bus-off (state code 2) and leaves the counter unchanged. While bus-off, no event strobe changes either counter.
- R11: While bus-off, the 128th `rec11_i` pulse clears both counters and the receive-passive flag and returns the node to error-active.
- R12: Outside bus-off, the state is error-passive (code 1) when the transmit counter exceeds 127 or the receive-passive flag is set, and error-active otherwise. `flag_passive_o` is high whenever the state is not error-active.
- R13: `warn_o` is high whenever either counter is 96 or more.
- R14: In one cycle, only the largest applicable change is made to each counter: an add of 8 overrides an add of 1, and either add overrides a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_tx_i | input | 1 | 1 = node is transmitter of the current frame |
| err_det_i | input | 1 | Error detected (counted for receiver) |
| err_in_flag_i | input | 1 | Qualifier: error found while sending an active error or overload flag |
| flag_start_i | input | 1 | Node starts an error flag |
| exc_ack_i | input | 1 | Qualifier: passive ACK error with no dominant bit during the passive flag |
| exc_stuff_i | input | 1 | Qualifier: arbitration stuff error, recessive stuff bit read as dominant |
| ovl_start_i | input | 1 | Node starts an overload flag |
| flag_bit_err_i | input | 1 | Bit error while sending an active error or overload flag |
| first_dom_i | input | 1 | First bit after the own error flag was dominant |
| dom_bit_i | input | 1 | One more consecutive dominant bit after a flag |
| dom_break_i | input | 1 | Dominant run ended |
| tx_ok_i | input | 1 | Transmission completed without error |
| rx_ok_i | input | 1 | Reception completed without error |
| rec11_i | input | 1 | 11 consecutive recessive bits seen |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 7 | Receive error counter |
| rx_passive_o | output | 1 | Receive-passive flag |
| state_o | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| flag_passive_o | output | 1 | Send passive error flag for an error in this cycle |
| warn_o | output | 1 | Either counter is at 96 or more |

## Verification
The bench drives the transmit counter into the 248 to 255 band with runs of add-8 events. A design that wraps at 256 would return to a low count and stay error-active instead of entering bus-off. It also counts the dominant-bit runs after both flag kinds. A design that used the 14-bit threshold again after the first penalty, or used it after a passive flag, would add penalties in the wrong cycles. It pushes the receive counter past 127 to reach the reload to 119, and fires simultaneous events to check the priority among the changes. A design that decremented instead of reloading, or that summed simultaneous adds, would drift from the reference model within a few cycles.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } node_st_e;
endpackage

// File: rtl/can_fc_domrun.sv
// Counts consecutive dominant bits after a flag and emits a penalty strobe
// when a run threshold is reached (long first run after an active flag).
module can_fc_domrun #(
  parameter int FIRST_RUN = 14,
  parameter int NEXT_RUN  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_start_i,
  input  logic pas_start_i,
  input  logic dom_bit_i,
  input  logic dom_break_i,
  output logic penalty_o
);
  localparam int MAXR  = (FIRST_RUN > NEXT_RUN) ? FIRST_RUN : NEXT_RUN;
  localparam int CNT_W = $clog2(MAXR + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;
  logic             kindp_q, kindp_d;
  logic [CNT_W-1:0] thr;

  always_comb begin
    cnt_d     = cnt_q;
    first_d   = first_q;
    kindp_d   = kindp_q;
    penalty_o = 1'b0;
    thr       = (kindp_q || first_q) ? CNT_W'(NEXT_RUN) : CNT_W'(FIRST_RUN);
    if (act_start_i || pas_start_i) begin
      kindp_d = pas_start_i && !act_start_i;
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (dom_break_i) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (dom_bit_i) begin
      if (cnt_q + CNT_W'(1) == thr) begin
        penalty_o = 1'b1;
        cnt_d     = '0;
        first_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      kindp_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      kindp_q <= kindp_d;
    end
  end
endmodule

// File: rtl/can_fc_tec.sv
// Transmit error counter with bus-off detection on an add in the top band.
module can_fc_tec #(
  parameter int W      = 8,
  parameter int STEP   = 8,
  parameter int SAT_LO = 248
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         freeze_i,
  input  logic         clear_i,
  output logic [W-1:0] tec_o,
  output logic         ovf_o
);
  logic [W-1:0] tec_q, tec_d;
  logic         en;

  assign ovf_o = inc_i && !freeze_i && (tec_q >= W'(SAT_LO));
  assign en    = clear_i || (!freeze_i && (inc_i || dec_i));

  always_comb begin
    tec_d = tec_q;
    if (clear_i) begin
      tec_d = '0;
    end else if (inc_i) begin
      if (tec_q < W'(SAT_LO)) tec_d = tec_q + W'(STEP);
    end else if (dec_i) begin
      if (tec_q != '0) tec_d = tec_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tec_q <= '0;
    else if (en) tec_q <= tec_d;
  end

  assign tec_o = tec_q;
endmodule

// File: rtl/can_fc_rec.sv
// Receive error counter with saturation into the receive-passive flag and
// reload on a clean reception while passive.
module can_fc_rec #(
  parameter int W      = 7,
  parameter int STEP   = 8,
  parameter int RELOAD = 119
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc8_i,
  input  logic         inc1_i,
  input  logic         ok_i,
  input  logic         freeze_i,
  input  logic         clear_i,
  output logic [W-1:0] rec_o,
  output logic         pas_o
);
  localparam int MAXV = (1 << W) - 1;

  logic [W-1:0] rec_q, rec_d;
  logic         pas_q, pas_d;
  logic [W:0]   sum;
  logic         inc_any;
  logic         en;

  assign inc_any = (inc8_i || inc1_i) && !pas_q;
  assign sum     = {1'b0, rec_q} + (inc8_i ? (W+1)'(STEP) : (W+1)'(1));
  assign en      = clear_i || (!freeze_i && (inc_any || ok_i));

  always_comb begin
    rec_d = rec_q;
    pas_d = pas_q;
    if (clear_i) begin
      rec_d = '0;
      pas_d = 1'b0;
    end else if (inc_any) begin
      if (sum > (W+1)'(MAXV)) begin
        rec_d = W'(MAXV);
        pas_d = 1'b1;
      end else begin
        rec_d = sum[W-1:0];
      end
    end else if (ok_i) begin
      if (pas_q) begin
        rec_d = W'(RELOAD);
        pas_d = 1'b0;
      end else if (rec_q != '0) begin
        rec_d = rec_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
      pas_q <= 1'b0;
    end else if (en) begin
      rec_q <= rec_d;
      pas_q <= pas_d;
    end
  end

  assign rec_o = rec_q;
  assign pas_o = pas_q;
endmodule

// File: rtl/can_fc_recov.sv
// Counts recessive-sequence reports during bus-off; strobes on the last one.
module can_fc_recov #(
  parameter int COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_i,
  input  logic seq_i,
  output logic done_o
);
  localparam int CW = $clog2(COUNT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign done_o = busoff_i && seq_i && (cnt_q == CW'(COUNT - 1));
  assign en     = !busoff_i || seq_i;

  always_comb begin
    if (!busoff_i || done_o) cnt_d = '0;
    else                     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int TEC_W      = 8,
  parameter int REC_W      = 7,
  parameter int BIG_STEP   = 8,
  parameter int PASS_LVL   = 127,
  parameter int WARN_LVL   = 96,
  parameter int REC_RELOAD = 119,
  parameter int FIRST_RUN  = 14,
  parameter int NEXT_RUN   = 8,
  parameter int RECOV_CNT  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_tx_i,
  input  logic             err_det_i,
  input  logic             err_in_flag_i,
  input  logic             flag_start_i,
  input  logic             exc_ack_i,
  input  logic             exc_stuff_i,
  input  logic             ovl_start_i,
  input  logic             flag_bit_err_i,
  input  logic             first_dom_i,
  input  logic             dom_bit_i,
  input  logic             dom_break_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             rec11_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             rx_passive_o,
  output logic [1:0]       state_o,
  output logic             flag_passive_o,
  output logic             warn_o
);
  localparam int SAT_LO = (1 << TEC_W) - BIG_STEP;

  logic     busoff_q, busoff_d;
  logic     dom_pen;
  logic     act_start, pas_start;
  logic     tec_inc, rec_inc8, rec_inc1;
  logic     tec_ovf, recov_done;
  node_st_e st;

  // Flag kind is taken from the registered state, i.e. before this event.
  assign act_start = (flag_start_i && !flag_passive_o) || ovl_start_i;
  assign pas_start = flag_start_i && flag_passive_o && !ovl_start_i;

  can_fc_domrun #(.FIRST_RUN(FIRST_RUN), .NEXT_RUN(NEXT_RUN)) u_domrun (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_start_i(act_start),
    .pas_start_i(pas_start),
    .dom_bit_i  (dom_bit_i),
    .dom_break_i(dom_break_i),
    .penalty_o  (dom_pen)
  );

  assign tec_inc = role_tx_i &&
                   ((flag_start_i && !exc_ack_i && !exc_stuff_i) ||
                    flag_bit_err_i || dom_pen);
  assign rec_inc8 = !role_tx_i && (first_dom_i || flag_bit_err_i || dom_pen);
  assign rec_inc1 = !role_tx_i && err_det_i && !err_in_flag_i;

  can_fc_tec #(.W(TEC_W), .STEP(BIG_STEP), .SAT_LO(SAT_LO)) u_tec (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (tec_inc),
    .dec_i   (tx_ok_i),
    .freeze_i(busoff_q),
    .clear_i (recov_done),
    .tec_o   (tec_o),
    .ovf_o   (tec_ovf)
  );

  can_fc_rec #(.W(REC_W), .STEP(BIG_STEP), .RELOAD(REC_RELOAD)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc8_i  (rec_inc8),
    .inc1_i  (rec_inc1),
    .ok_i    (rx_ok_i),
    .freeze_i(busoff_q),
    .clear_i (recov_done),
    .rec_o   (rec_o),
    .pas_o   (rx_passive_o)
  );

  can_fc_recov #(.COUNT(RECOV_CNT)) u_recov (
    .clk     (clk),
    .rst_n   (rst_n),
    .busoff_i(busoff_q),
    .seq_i   (rec11_i),
    .done_o  (recov_done)
  );

  always_comb begin
    if (busoff_q) busoff_d = !recov_done;
    else          busoff_d = tec_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busoff_q <= 1'b0;
    else        busoff_q <= busoff_d;
  end

  always_comb begin
    if (busoff_q)
      st = ST_BUSOFF;
    else if ((tec_o > TEC_W'(PASS_LVL)) || rx_passive_o)
      st = ST_PASSIVE;
    else
      st = ST_ACTIVE;
  end

  assign state_o        = st;
  assign flag_passive_o = (st != ST_ACTIVE);
  assign warn_o         = (tec_o >= TEC_W'(WARN_LVL)) ||
                          ({1'b0, rec_o} >= (REC_W+1)'(WARN_LVL));
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       role_tx_i,
  input logic       err_det_i,
  input logic       flag_start_i,
  input logic       ovl_start_i,
  input logic       flag_bit_err_i,
  input logic       first_dom_i,
  input logic       dom_bit_i,
  input logic       tx_ok_i,
  input logic       rx_ok_i,
  input logic       rec11_i,
  input logic [7:0] tec_o,
  input logic [6:0] rec_o,
  input logic       rx_passive_o,
  input logic [1:0] state_o,
  input logic       warn_o
);
  // R9: the receive-passive flag is only ever held with a saturated counter
  p_pas_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_passive_o |-> (rec_o == 7'd127));

  // R10: bus-off only with a counter in the top band
  p_busoff_band_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> (tec_o >= 8'd248));

  // R10: bus-off holds the counter and stays without a recovery pulse
  p_busoff_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 2'd2) && !rec11_i) |=> ($stable(tec_o) && (state_o == 2'd2)));

  // R13: error-passive always implies a warning level
  p_passive_warn_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |-> warn_o);

  // R7: a lone clean transmission lowers a non-zero counter by one
  p_tx_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok_i && (state_o != 2'd2) && (tec_o != 8'd0) && !dom_bit_i &&
     !(role_tx_i && (flag_start_i || flag_bit_err_i)))
    |=> (tec_o == $past(tec_o) - 8'd1));

  // R8: a clean reception while receive-passive reloads the counter
  p_rx_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok_i && rx_passive_o && (state_o != 2'd2) && !rec11_i)
    |=> ((rec_o == 7'd119) && !rx_passive_o));

  // R2: one receiver error without other receive events adds at most one
  p_rx_err_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_det_i && !role_tx_i && !rx_passive_o && (state_o != 2'd2) &&
     !first_dom_i && !flag_bit_err_i && !dom_bit_i && !rx_ok_i &&
     !flag_start_i && !ovl_start_i)
    |=> ((rec_o == $past(rec_o)) || (rec_o == $past(rec_o) + 7'd1)));
endmodule

bind can_fault_conf can_fault_conf_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .role_tx_i     (role_tx_i),
  .err_det_i     (err_det_i),
  .flag_start_i  (flag_start_i),
  .ovl_start_i   (ovl_start_i),
  .flag_bit_err_i(flag_bit_err_i),
  .first_dom_i   (first_dom_i),
  .dom_bit_i     (dom_bit_i),
  .tx_ok_i       (tx_ok_i),
  .rx_ok_i       (rx_ok_i),
  .rec11_i       (rec11_i),
  .tec_o         (tec_o),
  .rec_o         (rec_o),
  .rx_passive_o  (rx_passive_o),
  .state_o       (state_o),
  .warn_o        (warn_o)
);

// File: tb/can_fault_conf_tb_top.sv
`timescale 1ns/1ps
module can_fault_conf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic role_tx = 0, err_det = 0, err_in_flag = 0, flag_start = 0;
  logic exc_ack = 0, exc_stuff = 0, ovl_start = 0, flag_bit_err = 0;
  logic first_dom = 0, dom_bit = 0, dom_break = 0, tx_ok = 0, rx_ok = 0;
  logic rec11 = 0;
  logic [7:0] tec;
  logic [6:0] rec;
  logic       rx_pas, flag_pas, warn;
  logic [1:0] state;

  can_fault_conf dut_i (
    .clk(clk), .rst_n(rst_n), .role_tx_i(role_tx), .err_det_i(err_det),
    .err_in_flag_i(err_in_flag), .flag_start_i(flag_start),
    .exc_ack_i(exc_ack), .exc_stuff_i(exc_stuff), .ovl_start_i(ovl_start),
    .flag_bit_err_i(flag_bit_err), .first_dom_i(first_dom),
    .dom_bit_i(dom_bit), .dom_break_i(dom_break), .tx_ok_i(tx_ok),
    .rx_ok_i(rx_ok), .rec11_i(rec11), .tec_o(tec), .rec_o(rec),
    .rx_passive_o(rx_pas), .state_o(state), .flag_passive_o(flag_pas),
    .warn_o(warn)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit compare_on = 0;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_tec, m_rec, m_rcnt, m_dcnt;
  bit m_pas, m_boff, m_dfirst, m_dkindp;

  function automatic int m_state();
    if (m_boff) return 2;
    if (m_tec > 127 || m_pas) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tec = 0; m_rec = 0; m_rcnt = 0; m_dcnt = 0;
      m_pas = 0; m_boff = 0; m_dfirst = 0; m_dkindp = 0;
    end else begin
      bit pen, fp, tinc;
      int rinc, thr;
      pen = 0;
      fp  = (m_state() != 0);
      if (flag_start || ovl_start) begin
        m_dkindp = flag_start && fp && !ovl_start;
        m_dcnt = 0; m_dfirst = 0;
      end else if (dom_break) begin
        m_dcnt = 0; m_dfirst = 0;
      end else if (dom_bit) begin
        thr = (m_dkindp || m_dfirst) ? 8 : 14;
        if (m_dcnt + 1 == thr) begin
          pen = 1; m_dcnt = 0; m_dfirst = 1;
        end else m_dcnt++;
      end
      if (m_boff) begin
        if (rec11) begin
          m_rcnt++;
          if (m_rcnt == 128) begin
            m_boff = 0; m_tec = 0; m_rec = 0; m_pas = 0; m_rcnt = 0;
          end
        end
      end else begin
        tinc = role_tx && ((flag_start && !exc_ack && !exc_stuff) ||
                           flag_bit_err || pen);
        if (tinc) begin
          if (m_tec >= 248) m_boff = 1;
          else m_tec += 8;
        end else if (tx_ok && m_tec > 0) m_tec--;
        rinc = 0;
        if (!role_tx) begin
          if (first_dom || flag_bit_err || pen) rinc = 8;
          else if (err_det && !err_in_flag) rinc = 1;
        end
        if (!m_pas && rinc != 0) begin
          if (m_rec + rinc > 127) begin m_rec = 127; m_pas = 1; end
          else m_rec += rinc;
        end else if (rx_ok) begin
          if (m_pas) begin m_rec = 119; m_pas = 0; end
          else if (m_rec > 0) m_rec--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(tec, m_tec, "R4 R5 R7 R10 tec");
      chk(rec, m_rec, "R2 R3 R8 R9 rec");
      chk(rx_pas, m_pas, "R9 rx_passive");
      chk(state, m_state(), "R11 R12 state");
      chk(flag_pas, m_state() != 0, "R12 flag_passive");
      chk(warn, (m_tec >= 96 || m_rec >= 96), "R13 warn");
    end
  end

  task automatic idle();
    {err_det, err_in_flag, flag_start, exc_ack, exc_stuff, ovl_start,
     flag_bit_err, first_dom, dom_bit, dom_break, tx_ok, rx_ok, rec11} = '0;
  endtask

  // Hold the current stimulus for one clock edge, then release it.
  task automatic step();
    @(negedge clk); #1;
    idle();
  endtask

  task automatic rand_cycle(input int bias_tx, input int perr);
    @(negedge clk); #1;
    role_tx      = ($urandom_range(99) < bias_tx);
    err_det      = ($urandom_range(99) < perr);
    err_in_flag  = ($urandom_range(99) < 20);
    flag_start   = ($urandom_range(99) < perr);
    exc_ack      = ($urandom_range(99) < 10);
    exc_stuff    = ($urandom_range(99) < 10);
    ovl_start    = ($urandom_range(99) < 3);
    flag_bit_err = ($urandom_range(99) < perr / 2);
    first_dom    = ($urandom_range(99) < perr / 2);
    dom_bit      = ($urandom_range(99) < 40);
    dom_break    = ($urandom_range(99) < 3);
    tx_ok        = ($urandom_range(99) < 15);
    rx_ok        = ($urandom_range(99) < 15);
    rec11        = ($urandom_range(99) < 30);
  endtask

  task automatic main_seq();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tec, 0, "R1 tec"); chk(rec, 0, "R1 rec"); chk(state, 0, "R1 state");
    chk(warn, 0, "R1 warn"); chk(flag_pas, 0, "R1 flag_passive");
    chk(rx_pas, 0, "R1 rx_passive");
    compare_on = 1;
    #1;
    role_tx = 1; flag_start = 1; step(); chk(tec, 8, "R4 flag add");
    flag_start = 1; exc_ack = 1; step(); chk(tec, 8, "R4 ack exception");
    flag_start = 1; exc_stuff = 1; step(); chk(tec, 8, "R4 stuff exception");
    tx_ok = 1; step(); chk(tec, 7, "R7 decrement");
    flag_bit_err = 1; step(); chk(tec, 15, "R5 tx bit error");
    role_tx = 0;
    err_det = 1; step(); chk(rec, 1, "R2 rx error");
    err_det = 1; err_in_flag = 1; step(); chk(rec, 1, "R2 in-flag ignored");
    first_dom = 1; step(); chk(rec, 9, "R3 first dominant");
    first_dom = 1; err_det = 1; rx_ok = 1; step(); chk(rec, 17, "R14 priority");
    // R6: active overload flag, 13 bits then the 14th penalises
    ovl_start = 1; step();
    for (int i = 0; i < 13; i++) begin dom_bit = 1; step(); end
    chk(rec, 17, "R6 no penalty before 14");
    dom_bit = 1; step(); chk(rec, 25, "R6 penalty at 14");
    for (int i = 0; i < 7; i++) begin dom_bit = 1; step(); end
    chk(rec, 25, "R6 no penalty before next 8");
    dom_bit = 1; step(); chk(rec, 33, "R6 penalty at next 8");
    dom_break = 1; step();
    rx_ok = 1; step(); chk(rec, 32, "R8 rx decrement");
    // R9 saturate into receive-passive, then reload
    for (int i = 0; i < 14; i++) begin first_dom = 1; step(); end
    chk(rec, 127, "R9 saturate"); chk(rx_pas, 1, "R9 flag set");
    chk(state, 1, "R12 passive"); chk(flag_pas, 1, "R12 passive flag type");
    err_det = 1; step(); chk(rec, 127, "R9 ignored while passive");
    // R6 passive flag: 8 bits penalise (tx role)
    role_tx = 1; flag_start = 1; step();
    for (int i = 0; i < 8; i++) begin dom_bit = 1; step(); end
    chk(tec, 31, "R6 passive run");
    rx_ok = 1; step(); chk(rec, 119, "R8 reload"); chk(rx_pas, 0, "R8 flag cleared");
    // R10 bus-off
    for (int i = 0; i < 40; i++) begin flag_start = 1; step(); end
    chk(state, 2, "R10 bus-off"); chk(tec, 255, "R10 held");
    tx_ok = 1; step(); chk(tec, 255, "R10 frozen");
    for (int i = 0; i < 127; i++) begin rec11 = 1; step(); end
    chk(state, 2, "R11 still bus-off at 127");
    rec11 = 1; step();
    chk(state, 0, "R11 recovered"); chk(tec, 0, "R11 tec cleared");
    chk(rec, 0, "R11 rec cleared");
    // Random phases
    for (int i = 0; i < 3000; i++) rand_cycle(20, 30);
    for (int i = 0; i < 3000; i++) rand_cycle(85, 40);
    for (int i = 0; i < 4000; i++) rand_cycle(50, 15);
    idle();
    @(negedge clk);
  endtask

  initial begin
    fork
      main_seq();
      begin
        while (cycles < 150000) begin @(posedge clk); cycles++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      end
    join_any
    compare_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule